// File: doc/BRIEF.md
# VLAN Tag Stripper with Re-Padding

This stage sits in an Ethernet receive path, after the frame parser and before the receive buffer. It takes one byte per handshake on a valid/ready stream with start-of-frame and end-of-frame markers. When bytes 12 and 13 of a frame (offsets counted from 0) hold 0x81 then 0x00, the frame carries a VLAN tag. The stage then removes that type field and the 16-bit tag control field that follows it. The removed control field appears on a side port.

The last four input bytes are the incoming frame check sequence. The stage checks it and does not forward it. A new CRC-32 is computed over the bytes that actually leave the stage and is appended to the frame. When stripping leaves fewer than 60 data bytes, zero bytes are added until the frame reaches the 64-byte minimum, unless padding is switched off by configuration. A frame whose incoming check fails still leaves the stage, but it is flagged and its new check sequence is deliberately wrong.

Control is one four-state machine. IDLE waits for a start-of-frame byte and moves to BODY when one is accepted. BODY streams data through a four-byte delay line. On the byte that ends the frame it moves to PAD if the data is short and padding is on, and to FCS otherwise. PAD emits zero bytes and moves to FCS once 60 data bytes have gone out. FCS emits the four check bytes and returns to IDLE after the last one.

Top module: `vlan_strip_pad`

## Requirements
- R1: After reset, out_valid and tag_valid are 0 and in_ready is 1.
- R2: A frame whose bytes 12 and 13 are not 0x81 followed by 0x00 leaves unchanged: same length, same bytes, and the same four FCS bytes when the input FCS is good.
- R3: A frame with 0x81 at byte 12 and 0x00 at byte 13 loses bytes 12 to 15 whatever the values of bytes 14 and 15. All other data bytes keep their order.
- R4: For each stripped frame, tag_valid is high for exactly one cycle and tag_value holds byte 14 in bits [15:8] and byte 15 in bits [7:0]. Untagged frames give no pulse.
- R5: With pad_disable = 0, a frame that has fewer than 60 data bytes after stripping is extended with 0x00 bytes to 60 data bytes, which gives 64 bytes with the FCS.
- R6: With pad_disable = 1, no padding is added, so a tagged frame leaves 4 bytes shorter than it arrived.
- R7: The output FCS is a CRC-32 over all output data and pad bytes. It uses the reflected form of polynomial 0x04C11DB7, starts from all ones, is inverted at the end, and is sent least-significant byte first.
- R8: If the input FCS is wrong, out_err is 1 on the end-of-frame beat and the output FCS is the correct value XOR 0xFFFFFFFF. A good frame never raises out_err.
- R9: Frames from 64 bytes up to at least 1600 bytes pass, tagged or not.
- R10: While out_valid is high and out_ready is low, no byte is lost or duplicated, and out_data holds during padding and FCS output.
- R11: out_sof is high only on the first output byte and out_eof only on the last FCS byte.
- R12: In IDLE, bytes that arrive without in_sof are accepted and discarded, and produce no output.
- R13: in_ready is low while padding or FCS bytes are being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_disable | input | 1 | 1 turns off padding of short stripped frames |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Stage accepts the input byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame (last FCS byte) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |
| out_err | output | 1 | Input FCS failed; valid with out_eof |
| tag_valid | output | 1 | One-cycle pulse when a tag was removed |
| tag_value | output | 16 | Removed tag control field |

## Verification
Two events can land in the same clock cycle. First, the tag is dropped on the beat that delivers byte 16, and downstream may be stalling on that same beat. Second, the end-of-frame byte is accepted, and on that edge the machine chooses between PAD and FCS while the last data byte is still waiting on out_ready. The bench covers every combination of tagged or untagged, padding on or off, and lengths 64 to 72, using three stall patterns that shift against frame position. Each result is judged by rebuilding the expected byte sequence arithmetically and comparing length, bytes, FCS, markers and the tag pulse.

// File: rtl/vlsp_pkg.sv
package vlsp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_PAD,
        ST_FCS
    } vlsp_state_e;

    localparam logic [31:0] CRC_INIT         = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL    = 32'hEDB8_8320;
    localparam logic [31:0] CRC_GOOD_RESIDUE = 32'hDEBB_20E3;

    // one byte through the reflected CRC-32 register, LSB first
    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/vlsp_crc32.sv
module vlsp_crc32
    import vlsp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        start,
    input  logic [7:0]  data,
    output logic [31:0] crc
);

    logic [31:0] crc_q;

    // start restarts the register from all ones on the same byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_INIT;
        end else if (en) begin
            crc_q <= crc32_byte(start ? CRC_INIT : crc_q, data);
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/vlsp_delay.sv
module vlsp_delay #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               restart,
    input  logic [W-1:0]       din,
    output logic [W-1:0]       oldest,
    output logic               full,
    output logic [DEPTH*W-1:0] taps
);

    localparam int FILL_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][W-1:0] stage_q;
    logic [FILL_W-1:0]       fill_q;

    // stage 0 holds the newest byte; restart leaves only din inside
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            fill_q  <= '0;
        end else if (push || restart) begin
            stage_q <= {stage_q[DEPTH-2:0], din};
            if (restart) begin
                fill_q <= FILL_W'(1);
            end else if (fill_q != FILL_W'(DEPTH)) begin
                fill_q <= fill_q + FILL_W'(1);
            end
        end
    end

    assign oldest = stage_q[DEPTH-1];
    assign full   = (fill_q == FILL_W'(DEPTH));
    assign taps   = stage_q;

endmodule

// File: rtl/vlan_strip_pad.sv
module vlan_strip_pad
    import vlsp_pkg::*;
#(
    parameter int          ADDR_BYTES = 12,
    parameter int          MIN_FRAME  = 64,
    parameter int          MAX_FRAME  = 2047,
    parameter logic [15:0] TPID       = 16'h8100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pad_disable,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_sof,
    output logic        out_eof,
    output logic        out_err,
    output logic        tag_valid,
    output logic [15:0] tag_value
);

    localparam int FCS_BYTES = 4;
    localparam int TAG_BYTES = 4;
    localparam int MIN_DATA  = MIN_FRAME - FCS_BYTES;
    localparam int TAG_POS   = ADDR_BYTES + TAG_BYTES;
    localparam int LEN_W     = $clog2(MAX_FRAME + 1);
    localparam int POS_W     = $clog2(TAG_POS + 2);

    vlsp_state_e state_q, state_d;

    logic [POS_W-1:0] in_pos_q;
    logic [LEN_W-1:0] out_cnt_q;
    logic [LEN_W-1:0] cnt_after;
    logic [1:0]       fcs_idx_q;
    logic             tag_valid_q;
    logic [15:0]      tag_value_q;

    logic                     dl_push, dl_restart, dl_full;
    logic [7:0]               dl_oldest;
    logic [TAG_BYTES*8-1:0]   dl_taps;

    logic [31:0] in_crc, out_crc, fcs_word;
    logic        crc_bad;

    logic       in_ready_c, out_valid_c, out_sof_c, out_eof_c, out_err_c;
    logic [7:0] out_data_c;
    logic       tag_hit, tag_take, in_fire, emit;
    logic       ic_en, oc_en;

    vlsp_delay #(
        .DEPTH (TAG_BYTES),
        .W     (8)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (dl_push),
        .restart (dl_restart),
        .din     (in_data),
        .oldest  (dl_oldest),
        .full    (dl_full),
        .taps    (dl_taps)
    );

    // checks every received byte, incoming FCS included
    vlsp_crc32 u_crc_in (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ic_en),
        .start (state_q == ST_IDLE),
        .data  (in_data),
        .crc   (in_crc)
    );

    // covers every emitted data and pad byte
    vlsp_crc32 u_crc_out (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (oc_en),
        .start (out_cnt_q == '0),
        .data  (out_data_c),
        .crc   (out_crc)
    );

    assign crc_bad  = (in_crc != CRC_GOOD_RESIDUE);
    assign fcs_word = crc_bad ? out_crc : ~out_crc;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- outputs and datapath steering ----------------
    always_comb begin
        in_ready_c  = 1'b0;
        out_valid_c = 1'b0;
        out_data_c  = 8'h00;
        out_sof_c   = 1'b0;
        out_eof_c   = 1'b0;
        out_err_c   = 1'b0;
        dl_push     = 1'b0;
        dl_restart  = 1'b0;
        tag_hit     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready_c = 1'b1;
                dl_restart = in_valid && in_sof;
            end
            ST_BODY: begin
                tag_hit = dl_full && (in_pos_q == POS_W'(TAG_POS)) &&
                          (dl_taps[31:16] == TPID);
                if (tag_hit || !dl_full) begin
                    in_ready_c = 1'b1;
                    dl_restart = tag_hit && in_valid;
                    dl_push    = !tag_hit && in_valid;
                end else begin
                    in_ready_c  = out_ready;
                    out_valid_c = in_valid;
                    out_data_c  = dl_oldest;
                    out_sof_c   = (out_cnt_q == '0);
                    dl_push     = in_valid && out_ready;
                end
            end
            ST_PAD: begin
                out_valid_c = 1'b1;
            end
            ST_FCS: begin
                out_valid_c = 1'b1;
                out_data_c  = fcs_word[fcs_idx_q*8 +: 8];
                out_eof_c   = (fcs_idx_q == 2'd3);
                out_err_c   = (fcs_idx_q == 2'd3) && crc_bad;
            end
            default: begin
                in_ready_c = 1'b0;
            end
        endcase
        in_fire  = in_valid && in_ready_c;
        emit     = out_valid_c && out_ready;
        tag_take = tag_hit && in_valid;
        ic_en    = in_fire && ((state_q == ST_BODY) || ((state_q == ST_IDLE) && in_sof));
        oc_en    = emit && ((state_q == ST_BODY) || (state_q == ST_PAD));
    end

    assign cnt_after = out_cnt_q + LEN_W'(emit);

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid && in_sof) state_d = ST_BODY;
            ST_BODY: if (in_fire && in_eof) begin
                state_d = (pad_disable || (cnt_after >= LEN_W'(MIN_DATA))) ? ST_FCS : ST_PAD;
            end
            ST_PAD:  if (emit && (out_cnt_q == LEN_W'(MIN_DATA - 1))) state_d = ST_FCS;
            ST_FCS:  if (emit && (fcs_idx_q == 2'd3)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- counters and tag capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_pos_q    <= '0;
            out_cnt_q   <= '0;
            fcs_idx_q   <= '0;
            tag_valid_q <= 1'b0;
            tag_value_q <= '0;
        end else begin
            tag_valid_q <= tag_take;
            if (tag_take) begin
                tag_value_q <= dl_taps[15:0];
            end
            if (state_q == ST_IDLE) begin
                in_pos_q <= (in_valid && in_sof) ? POS_W'(1) : '0;
            end else if (in_fire && (in_pos_q != POS_W'(TAG_POS + 1))) begin
                in_pos_q <= in_pos_q + POS_W'(1);
            end
            if (state_q == ST_IDLE) begin
                out_cnt_q <= '0;
            end else if (oc_en) begin
                out_cnt_q <= out_cnt_q + LEN_W'(1);
            end
            if (state_q != ST_FCS) begin
                fcs_idx_q <= '0;
            end else if (emit) begin
                fcs_idx_q <= fcs_idx_q + 2'd1;
            end
        end
    end

    assign in_ready  = in_ready_c;
    assign out_valid = out_valid_c;
    assign out_data  = out_data_c;
    assign out_sof   = out_sof_c;
    assign out_eof   = out_eof_c;
    assign out_err   = out_err_c;
    assign tag_valid = tag_valid_q;
    assign tag_value = tag_value_q;

    // ---------------- assertions ----------------
    // R5: with padding on, the check sequence never starts before 60 data bytes
    a_r5_pad_reaches_min: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FCS && !pad_disable) |-> (out_cnt_q >= LEN_W'(MIN_DATA)));

    // R6: padding is entered only when it was enabled at end of frame
    a_r6_no_pad_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAD && $past(state_q) == ST_BODY) |-> !$past(pad_disable));

    // R10: a stalled pad or FCS byte stays on the output
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && state_q != ST_BODY) |=> (out_valid && $stable(out_data)));

    // R11: a frame never starts and ends on the same byte
    a_r11_sof_eof_apart: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_sof && out_eof));

    // R4: the tag pulse lasts a single cycle
    a_r4_tag_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |=> !tag_valid);

endmodule

// File: tb/vlan_strip_pad_test.sv
module vlan_strip_pad_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pad_disable = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        out_sof, out_eof, out_err;
    logic        tag_valid;
    logic [15:0] tag_value;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;
    int tag_pulses = 0;
    logic [15:0] tag_seen = '0;

    logic [7:0] in_b  [0:1699];
    logic [7:0] exp_b [0:1699];
    logic [7:0] got_b [0:1699];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tag_valid) begin
            tag_pulses = tag_pulses + 1;
            tag_seen   = tag_value;
        end
    end

    vlan_strip_pad uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pad_disable (pad_disable),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .in_sof      (in_sof),
        .in_eof      (in_eof),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_sof     (out_sof),
        .out_eof     (out_eof),
        .out_err     (out_err),
        .tag_valid   (tag_valid),
        .tag_value   (tag_value)
    );

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            if (r[0] ^ d[k]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    // kind: 0 plain, 1 tagged, 2 type 0x8101, 3 type 0x88A8
    task automatic run_frame(input int len, input int kind, input logic [15:0] tci,
                             input bit bad, input bit pad_off, input int bp,
                             input string req);
        logic [31:0] c;
        int j, data_len, exp_len, got_len, bad_sof, err_mid, leak, hold_bad;
        int mism_data, mism_fcs;
        bit err_last, done, stalled;
        logic [7:0] stall_data;

        for (int i = 0; i < len - 4; i++) in_b[i] = 8'((i * 37 + len + 11) & 255);
        case (kind)
            1:       begin in_b[12] = 8'h81; in_b[13] = 8'h00; in_b[14] = tci[15:8]; in_b[15] = tci[7:0]; end
            2:       begin in_b[12] = 8'h81; in_b[13] = 8'h01; end
            3:       begin in_b[12] = 8'h88; in_b[13] = 8'hA8; end
            default: begin in_b[12] = 8'h08; in_b[13] = 8'h00; end
        endcase
        c = 32'hFFFFFFFF;
        for (int i = 0; i < len - 4; i++) c = crc_step(c, in_b[i]);
        c = ~c;
        for (int k = 0; k < 4; k++) in_b[len - 4 + k] = c[k*8 +: 8];
        if (bad) in_b[len - 1] = in_b[len - 1] ^ 8'h5A;

        j = 0;
        for (int i = 0; i < len - 4; i++) begin
            if (!(kind == 1 && i >= 12 && i < 16)) begin
                exp_b[j] = in_b[i];
                j++;
            end
        end
        data_len = j;
        if (!pad_off) while (j < 60) begin exp_b[j] = 8'h00; j++; end
        c = 32'hFFFFFFFF;
        for (int i = 0; i < j; i++) c = crc_step(c, exp_b[i]);
        c = ~c;
        if (bad) c = ~c;
        for (int k = 0; k < 4; k++) exp_b[j + k] = c[k*8 +: 8];
        exp_len = j + 4;

        @(negedge clk);
        pad_disable = pad_off;
        tag_pulses = 0;
        got_len = 0; bad_sof = 0; err_mid = 0; leak = 0; hold_bad = 0;
        err_last = 1'b0; done = 1'b0; stalled = 1'b0; stall_data = 8'h00;

        fork
            begin
                int i;
                i = 0;
                while (i < len) begin
                    @(negedge clk);
                    if (bp == 2 && (cyc % 3) == 1) begin
                        in_valid = 1'b0;
                    end else begin
                        in_valid = 1'b1;
                        in_data  = in_b[i];
                        in_sof   = (i == 0);
                        in_eof   = (i == len - 1);
                        #1;
                        if (in_ready) i++;
                    end
                end
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
            end
            begin
                while (!done) begin
                    @(negedge clk);
                    if (bp == 0)      out_ready = 1'b1;
                    else if (bp == 1) out_ready = ((cyc % 5) >= 2);
                    else              out_ready = ((cyc % 4) != 0);
                    #1;
                    if (stalled && out_valid && out_data != stall_data) hold_bad++;
                    stalled = 1'b0;
                    if (out_valid && out_ready) begin
                        if (got_len < 1700) got_b[got_len] = out_data;
                        if (out_sof != (got_len == 0)) bad_sof++;
                        if (got_len >= data_len && in_ready) leak++;
                        if (out_eof) begin
                            done = 1'b1;
                            err_last = out_err;
                        end else if (out_err) begin
                            err_mid++;
                        end
                        got_len++;
                        if (got_len >= 1700) done = 1'b1;
                    end else if (out_valid) begin
                        stalled = 1'b1;
                        stall_data = out_data;
                    end
                end
                out_ready = 1'b1;
            end
        join

        mism_data = 0; mism_fcs = 0;
        if (got_len == exp_len) begin
            for (int i = 0; i < exp_len - 4; i++) if (got_b[i] !== exp_b[i]) mism_data++;
            for (int i = exp_len - 4; i < exp_len; i++) if (got_b[i] !== exp_b[i]) mism_fcs++;
        end
        chk(got_len == exp_len, req, "output length", got_len, exp_len);
        chk(mism_data == 0, req, "data byte mismatches", mism_data, 0);
        chk(mism_fcs == 0, bad ? "R8" : "R7", "FCS byte mismatches", mism_fcs, 0);
        chk(bad_sof == 0, "R11", "misplaced out_sof", bad_sof, 0);
        chk(err_last == bad && err_mid == 0, "R8", "out_err on eof", int'(err_last), int'(bad));
        chk(tag_pulses == (kind == 1 ? 1 : 0), "R4", "tag pulses", tag_pulses, kind == 1 ? 1 : 0);
        if (kind == 1) chk(tag_seen == tci, "R4", "tag value", int'(tag_seen), int'(tci));
        chk(leak == 0, "R13", "in_ready high during pad/FCS", leak, 0);
        if (bp != 0) chk(hold_bad == 0, "R10", "stalled byte changed", hold_bad, 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int leak;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0 && tag_valid == 1'b0 && in_ready == 1'b1, "R1",
            "reset state", int'({out_valid, tag_valid, in_ready}), 1);

        // R12: stray bytes without a start marker
        leak = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'(8'h81 + k);
            #1;
            if (out_valid) leak++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(leak == 0, "R12", "output from stray bytes", leak, 0);
        run_frame(64, 1, 16'h0123, 1'b0, 1'b0, 0, "R12");

        // sweep: pad on/off x tagged/untagged x length 64..72 x stall pattern
        for (int p = 0; p < 2; p++) begin
            for (int kd = 0; kd < 2; kd++) begin
                for (int ln = 64; ln <= 72; ln++) begin
                    run_frame(ln, kd, {8'(ln), ~8'(ln)}, 1'b0, p[0], ln % 3,
                              kd == 0 ? "R2" : (p == 1 ? "R6" : "R3 R5"));
                end
            end
        end

        // tag contents extremes and look-alike types
        run_frame(64, 1, 16'hFFFF, 1'b0, 1'b0, 1, "R3");
        run_frame(65, 1, 16'h0000, 1'b0, 1'b0, 2, "R3");
        run_frame(66, 2, 16'h0000, 1'b0, 1'b0, 1, "R2");
        run_frame(66, 3, 16'h0000, 1'b0, 1'b0, 2, "R2");

        // bad incoming FCS
        run_frame(64, 1, 16'h0ABC, 1'b1, 1'b0, 1, "R8");
        run_frame(80, 0, 16'h0000, 1'b1, 1'b0, 0, "R8");
        run_frame(64, 1, 16'h5555, 1'b1, 1'b1, 2, "R8");

        // long frames
        run_frame(1600, 1, 16'hE00F, 1'b0, 1'b0, 2, "R9");
        run_frame(1518, 0, 16'h0000, 1'b0, 1'b0, 1, "R9");
        run_frame(1600, 0, 16'h0000, 1'b0, 1'b1, 0, "R9");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule